// File: doc/BRIEF.md
# SPI Master Character Engine

This block moves one SPI character per 32-bit transmit word. Words wait in a small transmit queue. The engine takes the word at the head of the queue and shifts out a character of 4 to 16 bits, or of a full 32 bits. At the same time it shifts the incoming line into a receive accumulator. When the character is complete, the engine places the received bits at a fixed position in a 32-bit receive word and stores that word in a receive queue. The position depends on the selected bit order, so software always finds the character in the same place.

Serial clock edges come from a strobe input, `sck_tick`, that an external divider provides. Each strobe moves the serial clock half a period. The block reports three event flags at fixed bit positions: room in the transmit queue, data in the receive queue, and a sticky receive overrun. A select register drives active-low slave-select lines. A loopback option feeds the outgoing data line straight back into the receiver.

Top module: `spi_word_engine`

## Requirements
- R1: After reset, every `ss_n` line is high, `sck` is low, `events[8]` is 1, and all other `events` bits are 0.
- R2: The character length is `cfg_len`+1 bits when `cfg_wide`=0, which gives 4 to 16 bits for `cfg_len` 3 to 15. When `cfg_wide`=1 the length is 32 bits and `cfg_len` is ignored. Each transmit word produces exactly that many `sck` rising edges.
- R3: When `cfg_msb_first`=1 and the length N is below 32, the transmitted bits are word bits 31 down to 32−N, in that order. The received character lands in bits [15+N:16], with the first received bit most significant. All other bits of the receive word are 0.
- R4: When `cfg_msb_first`=0 and the length N is below 32, the transmitted bits are word bits 0 up to N−1, in that order. The received character lands in bits [15:16−N], with the first received bit at bit 16−N. All other bits of the receive word are 0.
- R5: With 32-bit characters, both directions use the whole word with no shift. MSB-first order starts at bit 31. LSB-first order starts at bit 0.
- R6: `sck` idles low. It changes only on a cycle with `sck_tick`=1. Each bit takes one rising edge and one falling edge. `mosi` holds steady while `sck` is high. The receiver samples its input on the rising edge.
- R7: With `cfg_loop`=1 the receiver takes `mosi`, and `miso` has no effect on the received word.
- R8: `events[8]` is 1 while the transmit queue has room. `events[9]` is 1 while the receive queue holds a word. `events[12]` is the sticky overrun flag; writing 1 to bit 12 of `evt_clr_mask` clears it, and writing 0 there leaves it set.
- R9: If a character completes while the receive queue is full, the engine drops it and sets `events[12]`. The words already queued stay unchanged.
- R10: A character starts only when `cfg_en`=1 and the transmit queue is non-empty. When the queue runs dry, the engine stops at the end of the current character with `sck` low.
- R11: A cycle with `sel_we`=1 loads `sel_wdata` into `ss_n`. No other cycle changes `ss_n`. Slave k is selected by clearing bit k−1.
- R12: Both queues keep write order. `rx_rdata` shows the head of the receive queue and `rx_re` removes it. A write to a full transmit queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_tick | input | 1 | Half-period strobe for the serial clock |
| cfg_en | input | 1 | Allows new characters to start |
| cfg_loop | input | 1 | Receiver takes mosi instead of miso |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_wide | input | 1 | 1: 32-bit characters |
| cfg_len | input | 4 | Character length minus one |
| tx_we | input | 1 | Push transmit word |
| tx_wdata | input | 32 | Transmit word |
| rx_re | input | 1 | Pop receive word |
| rx_rdata | output | 32 | Head of the receive queue |
| evt_clr_mask | input | 16 | Write-one-to-clear mask for the events |
| evt_clr_we | input | 1 | Applies evt_clr_mask |
| events | output | 16 | Bit 8 room, bit 9 data, bit 12 overrun |
| sel_we | input | 1 | Load the select register |
| sel_wdata | input | NSEL | New select value |
| ss_n | output | NSEL | Active-low slave selects |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with a transmit depth of 4 and a receive depth of 2. The receive queue therefore uses the ring variant of the queue. With only two receive slots, an overrun takes just three unread characters, and filling the transmit queue takes four pushes, so both full boundaries are reached within a few hundred cycles. With NSEL=4 the bench can walk the select bit through every slave. A slave model drives `miso` from a random bit pattern. This lets the bench check both bit orders, every length from 4 to 16 bits, and 32-bit characters, with loopback on and off.

// File: rtl/spi_we_pkg.sv
package spi_we_pkg;
   localparam int WORD_W    = 32;
   localparam int RX_ANCHOR = 16;
   localparam int CNT_W     = $clog2(WORD_W + 1);
   localparam int EV_NF     = 8;
   localparam int EV_NE     = 9;
   localparam int EV_OV     = 12;
   localparam int EV_W      = 16;

   typedef enum logic {ST_IDLE, ST_RUN} eng_state_t;
endpackage

// File: rtl/spi_we_fifo.sv
module spi_we_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("queue depth must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] q;
      logic         v;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
            v <= 1'b0;
         end else if (push && !v) begin
            q <= din;
            v <= 1'b1;
         end else if (pop && v) begin
            v <= 1'b0;
         end
      end
      assign dout  = q;
      assign full  = v;
      assign empty = !v;
   end else begin : g_ring
      logic [W-1:0]  mem [DEPTH];
      logic [AW-1:0] wp, rp;
      logic [CW-1:0] cnt;
      logic          do_push, do_pop;

      assign do_push = push && (cnt != CW'(DEPTH));
      assign do_pop  = pop && (cnt != '0);

      always_ff @(posedge clk) begin
         if (do_push) mem[wp] <= din;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
         end
      end

      assign dout  = mem[rp];
      assign full  = (cnt == CW'(DEPTH));
      assign empty = (cnt == '0);

      assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CW'(DEPTH));
   end
endmodule

// File: rtl/spi_we_shift.sv
module spi_we_shift
   import spi_we_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic [WORD_W-1:0] start_word,
   input  logic [CNT_W-1:0]  nbits,
   input  logic              msb_first,
   input  logic              wide,
   input  logic              loop,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic              sck,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_word
);
   eng_state_t        st;
   logic [WORD_W-1:0] sr, acc;
   logic [CNT_W-1:0]  cnt;
   logic              sck_q, msb_q, wide_q, done_q, rx_bit;

   assign mosi   = msb_q ? sr[WORD_W-1] : sr[0];
   assign rx_bit = loop ? mosi : miso;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sr     <= '0;
         acc    <= '0;
         cnt    <= '0;
         sck_q  <= 1'b0;
         msb_q  <= 1'b1;
         wide_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               sr     <= start_word;
               acc    <= '0;
               cnt    <= nbits;
               msb_q  <= msb_first;
               wide_q <= wide;
               sck_q  <= 1'b0;
               st     <= ST_RUN;
            end
            ST_RUN: if (tick) begin
               if (!sck_q) begin
                  sck_q <= 1'b1;
                  acc   <= msb_q ? {acc[WORD_W-2:0], rx_bit} : {rx_bit, acc[WORD_W-1:1]};
               end else begin
                  sck_q <= 1'b0;
                  sr    <= msb_q ? (sr << 1) : (sr >> 1);
                  cnt   <= cnt - 1'b1;
                  if (cnt == CNT_W'(1)) begin
                     st     <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st == ST_RUN);
   assign done    = done_q;
   assign sck     = sck_q;
   assign rx_word = wide_q ? acc : (msb_q ? (acc << RX_ANCHOR) : (acc >> RX_ANCHOR));

   assert_sck_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(sck));
   assert_mosi_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(mosi));
   assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
   import spi_we_pkg::*;
#(
   parameter int TX_DEPTH = 4,
   parameter int RX_DEPTH = 2,
   parameter int NSEL     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_tick,
   input  logic              cfg_en,
   input  logic              cfg_loop,
   input  logic              cfg_msb_first,
   input  logic              cfg_wide,
   input  logic [3:0]        cfg_len,
   input  logic              tx_we,
   input  logic [31:0]       tx_wdata,
   input  logic              rx_re,
   output logic [31:0]       rx_rdata,
   input  logic [15:0]       evt_clr_mask,
   input  logic              evt_clr_we,
   output logic [15:0]       events,
   input  logic              sel_we,
   input  logic [NSEL-1:0]   sel_wdata,
   output logic [NSEL-1:0]   ss_n,
   output logic              sck,
   output logic              mosi,
   input  logic              miso
);
   if (NSEL < 1 || NSEL > 32) begin : g_bad_nsel
      $error("NSEL must lie in 1..32");
   end
   if (TX_DEPTH < 1 || RX_DEPTH < 1) begin : g_bad_depths
      $error("queue depths must be at least 1");
   end

   logic [WORD_W-1:0] tx_head, rx_word;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic              busy, done, start, rx_push, ov_q;
   logic [CNT_W-1:0]  nbits;
   logic [NSEL-1:0]   ss_q;
   logic              unused_clr;

   assign unused_clr = ^{evt_clr_mask[15:13], evt_clr_mask[11:0]};
   assign nbits      = cfg_wide ? CNT_W'(WORD_W) : (CNT_W'(cfg_len) + 1'b1);
   assign start      = cfg_en && !busy && !tx_empty;
   assign rx_push    = done && !rx_full;

   spi_we_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_we), .din(tx_wdata), .pop(start),
      .dout(tx_head), .full(tx_full), .empty(tx_empty));

   spi_we_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word), .pop(rx_re),
      .dout(rx_rdata), .full(rx_full), .empty(rx_empty));

   spi_we_shift u_shift (
      .clk(clk), .rst_n(rst_n), .tick(sck_tick), .start(start),
      .start_word(tx_head), .nbits(nbits), .msb_first(cfg_msb_first),
      .wide(cfg_wide), .loop(cfg_loop), .miso(miso), .busy(busy),
      .done(done), .sck(sck), .mosi(mosi), .rx_word(rx_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_q <= 1'b0;
         ss_q <= '1;
      end else begin
         if (done && rx_full)                            ov_q <= 1'b1;
         else if (evt_clr_we && evt_clr_mask[EV_OV])     ov_q <= 1'b0;
         if (sel_we) ss_q <= sel_wdata;
      end
   end

   always_comb begin
      events        = '0;
      events[EV_NF] = !tx_full;
      events[EV_NE] = !rx_empty;
      events[EV_OV] = ov_q;
   end

   assign ss_n = ss_q;

   assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_we |=> $stable(ss_n));
   assert_ov_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ov_q) |-> $past(done && rx_full));
   assert_start_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cfg_en));
endmodule

// File: tb/sim_spi_word_engine.sv
module sim_spi_word_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck_tick = 1'b1;
   logic        cfg_en = 1'b0, cfg_loop = 1'b0, cfg_msb_first = 1'b1, cfg_wide = 1'b0;
   logic [3:0]  cfg_len = 4'd7;
   logic        tx_we = 1'b0, rx_re = 1'b0, evt_clr_we = 1'b0, sel_we = 1'b0;
   logic [31:0] tx_wdata = '0, rx_rdata;
   logic [15:0] evt_clr_mask = '0, events;
   logic [3:0]  sel_wdata = '1, ss_n;
   logic        sck, mosi, miso;

   int          n_checks = 0, n_fail = 0;
   logic        tick_rand = 1'b0;
   logic        mon_clr = 1'b0;
   logic        sck_prev = 1'b0;
   logic [5:0]  cap_n = '0;
   logic [31:0] cap_bits = '0;
   logic [31:0] slv_bits = '0;
   int          seed_v;

   spi_word_engine #(.TX_DEPTH(4), .RX_DEPTH(2), .NSEL(4)) u0 (
      .clk(clk), .rst_n(rst_n), .sck_tick(sck_tick), .cfg_en(cfg_en),
      .cfg_loop(cfg_loop), .cfg_msb_first(cfg_msb_first), .cfg_wide(cfg_wide),
      .cfg_len(cfg_len), .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re),
      .rx_rdata(rx_rdata), .evt_clr_mask(evt_clr_mask), .evt_clr_we(evt_clr_we),
      .events(events), .sel_we(sel_we), .sel_wdata(sel_wdata), .ss_n(ss_n),
      .sck(sck), .mosi(mosi), .miso(miso));

   always #4 clk = ~clk;

   // slave model: the next bit to present equals the count of rising edges seen
   assign miso = slv_bits[cap_n[4:0]];

   always @(posedge clk) begin
      if (mon_clr) begin
         cap_n    <= '0;
         cap_bits <= '0;
      end else if (sck && !sck_prev) begin
         cap_bits[cap_n[4:0]] <= mosi;
         cap_n <= cap_n + 1'b1;
      end
      sck_prev <= sck;
   end

   always @(negedge clk) sck_tick <= tick_rand ? (($urandom % 4) != 0) : 1'b1;

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] tx_bits(input logic [31:0] w, input int n, input logic msb);
      logic [31:0] b = '0;
      for (int i = 0; i < n; i++) b[i] = msb ? w[31-i] : w[i];
      return b;
   endfunction

   function automatic logic [31:0] rx_expect(input logic [31:0] b, input int n, input logic msb);
      logic [31:0] v = '0;
      for (int i = 0; i < n; i++) begin
         if (msb) v[n-1-i] = b[i];
         else     v[i]     = b[i];
      end
      if (n == 32) return v;
      return msb ? (v << 16) : (v << (16 - n));
   endfunction

   task automatic push(input logic [31:0] w);
      tx_wdata = w; tx_we = 1'b1;
      @(negedge clk);
      tx_we = 1'b0;
   endtask

   task automatic pop();
      rx_re = 1'b1;
      @(negedge clk);
      rx_re = 1'b0;
   endtask

   task automatic clear_mon();
      mon_clr = 1'b1;
      @(negedge clk);
      mon_clr = 1'b0;
   endtask

   task automatic wait_ne(input string tag);
      int k = 0;
      while (!events[9] && k < 3000) begin
         @(negedge clk);
         k++;
      end
      check(events[9], {tag, " timeout"}, {31'd0, events[9]}, 32'd1);
   endtask

   task automatic xfer(input logic [31:0] w, input logic [3:0] len, input logic msb,
                       input logic wide, input logic lp, input logic [31:0] sb);
      int n;
      logic [31:0] tb, rb, exp, mask;
      string otag;
      cfg_len = len; cfg_msb_first = msb; cfg_wide = wide; cfg_loop = lp;
      slv_bits = sb;
      clear_mon();
      push(w);
      n = wide ? 32 : int'(len) + 1;
      otag = wide ? "R5" : (msb ? "R3" : "R4");
      tb = tx_bits(w, n, msb);
      rb = lp ? tb : sb;
      exp = rx_expect(rb, n, msb);
      mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
      wait_ne(otag);
      @(negedge clk);
      check(rx_rdata == exp, lp ? {otag, " R7 rx"} : {otag, " rx"}, rx_rdata, exp);
      check(cap_n == 6'(n), "R2 bit count", {26'd0, cap_n}, n);
      check((cap_bits & mask) == tb, {otag, " R6 mosi"}, cap_bits & mask, tb);
      pop();
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] w [5];
      logic [31:0] got [5];
      int ngot;
      seed_v = $urandom(32'h5eed);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(ss_n == 4'hF, "R1 ss_n", {28'd0, ss_n}, 32'hF);
      check(sck == 1'b0, "R1 sck", {31'd0, sck}, 0);
      check(events == 16'h0100, "R1 R8 events", {16'd0, events}, 32'h100);

      // R11 slave select walk
      for (int k = 1; k <= 4; k++) begin
         sel_wdata = ~(4'd1 << (k - 1)); sel_we = 1'b1;
         @(negedge clk);
         sel_we = 1'b0; sel_wdata = 4'h0;
         @(negedge clk);
         check(ss_n == ~(4'd1 << (k - 1)), "R11 select", {28'd0, ss_n}, {28'd0, ~(4'd1 << (k - 1))});
      end
      sel_wdata = 4'hF; sel_we = 1'b1;
      @(negedge clk);
      sel_we = 1'b0;
      @(negedge clk);
      check(ss_n == 4'hF, "R11 deselect", {28'd0, ss_n}, 32'hF);

      // random transfers, loopback on and off, random tick gaps
      cfg_en = 1'b1;
      tick_rand = 1'b1;
      for (int t = 0; t < 60; t++) begin
         logic [3:0] ln;
         ln = 4'(3 + ($urandom % 13));
         xfer($urandom, ln, 1'($urandom), (($urandom % 4) == 0), (t < 30), $urandom);
      end
      // directed corners: shortest and longest characters, both orders, 32-bit ignoring len
      xfer(32'hA5C3_0F96, 4'd3,  1'b1, 1'b0, 1'b0, 32'h0000_0005);
      xfer(32'hA5C3_0F96, 4'd3,  1'b0, 1'b0, 1'b0, 32'h0000_000A);
      xfer(32'h8001_7FFE, 4'd15, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
      xfer(32'h8001_7FFE, 4'd15, 1'b0, 1'b0, 1'b0, 32'h0000_FFFF);
      xfer(32'h1234_5678, 4'd0,  1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF);
      xfer(32'h1234_5678, 4'd9,  1'b0, 1'b1, 1'b0, 32'hDEAD_BEEF);
      tick_rand = 1'b0;

      // R9 overrun with a two-entry receive queue
      cfg_len = 4'd7; cfg_msb_first = 1'b1; cfg_wide = 1'b0; cfg_loop = 1'b1;
      for (int i = 0; i < 3; i++) begin
         w[i] = $urandom;
         push(w[i]);
         repeat (40) @(negedge clk);
      end
      check(events[12], "R9 overrun set", {31'd0, events[12]}, 1);
      check(rx_rdata == {8'd0, w[0][31:24], 16'd0}, "R9 head kept", rx_rdata, {8'd0, w[0][31:24], 16'd0});
      pop();
      check(rx_rdata == {8'd0, w[1][31:24], 16'd0}, "R9 second kept", rx_rdata, {8'd0, w[1][31:24], 16'd0});
      pop();
      check(!events[9], "R9 third dropped", {31'd0, events[9]}, 0);
      evt_clr_mask = 16'hEFFF; evt_clr_we = 1'b1;
      @(negedge clk);
      evt_clr_we = 1'b0;
      check(events[12], "R8 clear with 0 keeps", {31'd0, events[12]}, 1);
      evt_clr_mask = 16'h1000; evt_clr_we = 1'b1;
      @(negedge clk);
      evt_clr_we = 1'b0;
      check(!events[12], "R8 clear with 1", {31'd0, events[12]}, 0);

      // R12 / R10 transmit queue full, held while disabled, then drained in order
      cfg_en = 1'b0;
      for (int i = 0; i < 5; i++) begin
         w[i] = $urandom;
         push(w[i]);
         if (i == 3) check(!events[8], "R12 tx full", {31'd0, events[8]}, 0);
      end
      repeat (20) @(negedge clk);
      check(!sck && !events[9], "R10 no start while disabled", {30'd0, sck, events[9]}, 0);
      cfg_en = 1'b1;
      ngot = 0;
      for (int c = 0; c < 600; c++) begin
         @(negedge clk);
         if (events[9] && !rx_re) begin
            if (ngot < 5) got[ngot] = rx_rdata;
            ngot++;
            rx_re = 1'b1;
         end else begin
            rx_re = 1'b0;
         end
      end
      rx_re = 1'b0;
      @(negedge clk);
      check(ngot == 4, "R12 full push ignored", ngot, 4);
      for (int i = 0; i < 4; i++)
         check(got[i] == {8'd0, w[i][31:24], 16'd0}, "R12 order", got[i], {8'd0, w[i][31:24], 16'd0});
      check(!sck && events[8], "R10 stopped idle", {30'd0, sck, events[8]}, 1);
      check(!events[12], "R9 no overrun while drained", {31'd0, events[12]}, 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule